// File: doc/BRIEF.md
# Destination Address Filter with Multicast Hash

This block makes the accept or reject decision for an incoming Ethernet frame from its 48-bit destination address alone. The address arrives one bit per valid cycle, least-significant bit first, and the first bit of a frame is flagged by a start-of-frame strobe. The first received bit tells the two kinds of address apart. An individual (unicast) address must match a 48-bit station address held in six byte-wide registers. A group (multicast) address is instead hashed: every address bit runs through a bit-serial CRC-32 generator. After the last address bit, six bits of the CRC pick one of 64 filter bits held in eight byte-wide registers. The frame is accepted if that filter bit is set.

Software loads the station address and the filter mask through a simple byte write port. The decision appears on registered outputs one cycle after the last address bit is sampled. It stays there until the next start-of-frame, so the surrounding receive logic can sample it at any point in the rest of the frame.

Top module: `dafilt_top`

## Requirements
- R1: After reset, `decisionValid`, `frameAccept` and `frameReject` are 0, and all station address and filter registers hold 0.
- R2: The first received address bit (index 0) selects the path. A 1 uses the multicast hash path only, even if the address equals the station address. A 0 uses the unicast comparison only, whatever the filter holds.
- R3: A unicast frame is accepted only when all 48 received bits equal the station address. Write address k (0 to 5) holds address bits 8k to 8k+7, with bit 8k in data bit 0. A difference in any single byte rejects the frame.
- R4: The hash index comes from a CRC-32 register, polynomial 0x04C11DB7, preset to all ones at the first address bit. Each bit b updates it as: feedback = crc[31] xor b, shift left by one, then xor with the polynomial if feedback is 1. After the 48th bit, the index is crc[31:26].
- R5: Filter bit n (0 to 63) is data bit n%8 of write address 8 + n/8. A multicast frame is accepted exactly when the filter bit at its hash index is 1.
- R6: The decision appears on the clock edge that samples address bit 47 and is visible in the next cycle. It holds unchanged until a start-of-frame is sampled. `frameAccept` and `frameReject` are never both 1, and each implies `decisionValid`.
- R7: A start-of-frame sampled with `bitValid` clears the decision on that edge and starts a new address with that bit as bit 0, even in the middle of an address.
- R8: Cycles with `bitValid` low, valid bits before any start-of-frame, and valid bits after bit 47 up to the next start-of-frame change neither the decision nor the address being assembled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| bitIn | input | 1 | Serial destination address bit, least-significant first |
| bitValid | input | 1 | `bitIn` carries a bit this cycle |
| sof | input | 1 | With `bitValid`, marks address bit 0 of a new frame |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 4 | Write address: 0-5 station address bytes, 8-15 filter bytes |
| regWrData | input | 8 | Write data |
| decisionValid | output | 1 | A decision for the current frame is available |
| frameAccept | output | 1 | Frame accepted |
| frameReject | output | 1 | Frame rejected |

## Verification
Unicast frames equal to the station address are mixed with frames that differ in exactly one byte, one frame for each byte position. This shows whether every register lane takes part in the comparison with the right bit order. Multicast addresses are sent with a filter that holds only the computed index bit, and again with only a neighbouring bit. This separates a correct CRC, index and bit-mapping from any near miss. Random addresses of both kinds run against random filters, with idle gaps and stray strobes between bits. Directed cases cover a path that crosses over (a station address with the group bit set), a restart in the middle of an address, and bits arriving after the decision.

// File: rtl/dafilt_pkg.sv
package dafilt_pkg;
  localparam int ADDR_BITS  = 48;
  localparam int BYTE_W     = 8;
  localparam int NUM_PHYS   = ADDR_BITS / BYTE_W;
  localparam int HASH_BITS  = 6;
  localparam int NUM_FILT   = (1 << HASH_BITS) / BYTE_W;
  localparam int CRC_W      = 32;
  localparam logic [CRC_W-1:0] CRC_POLY = 32'h04C11DB7;
  localparam int IDX_W      = $clog2(ADDR_BITS);
  localparam int RADDR_W    = 4;
  localparam int FILT_BASE  = 8;

  typedef struct packed {
    logic             start;
    logic             shift;
    logic             last;
    logic [IDX_W-1:0] bitIdx;
  } ctrlStrobes_t;
endpackage

// File: rtl/dafilt_ctrl.sv
module dafilt_ctrl
  import dafilt_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         bitValid,
  input  logic         sof,
  output ctrlStrobes_t strobes
);
  logic             active;
  logic [IDX_W-1:0] bitCnt;

  always_comb begin
    strobes.start  = bitValid & sof;
    strobes.shift  = bitValid & ~sof & active;
    strobes.bitIdx = strobes.start ? '0 : bitCnt;
    strobes.last   = strobes.shift && (bitCnt == IDX_W'(ADDR_BITS - 1));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      active <= 1'b0;
      bitCnt <= '0;
    end else if (strobes.start) begin
      active <= 1'b1;
      bitCnt <= IDX_W'(1);
    end else if (strobes.shift) begin
      if (strobes.last) begin
        active <= 1'b0;
        bitCnt <= '0;
      end else begin
        bitCnt <= bitCnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/dafilt_dpath.sv
module dafilt_dpath
  import dafilt_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               bitIn,
  input  ctrlStrobes_t       strobes,
  input  logic               regWrEn,
  input  logic [RADDR_W-1:0] regAddr,
  input  logic [BYTE_W-1:0]  regWrData,
  output logic               decValid,
  output logic               decAccept
);
  localparam int FILT_W = NUM_FILT * BYTE_W;

  logic [BYTE_W-1:0]    physReg [NUM_PHYS];
  logic [BYTE_W-1:0]    filtReg [NUM_FILT];
  logic [ADDR_BITS-1:0] physVec;
  logic [FILT_W-1:0]    filtVec;

  generate
    for (genvar k = 0; k < NUM_PHYS; k++) begin : g_phys
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) physReg[k] <= '0;
        else if (regWrEn && regAddr == RADDR_W'(k)) physReg[k] <= regWrData;
      end
      assign physVec[k*BYTE_W +: BYTE_W] = physReg[k];
    end
    for (genvar k = 0; k < NUM_FILT; k++) begin : g_filt
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) filtReg[k] <= '0;
        else if (regWrEn && regAddr == RADDR_W'(FILT_BASE + k)) filtReg[k] <= regWrData;
      end
      assign filtVec[k*BYTE_W +: BYTE_W] = filtReg[k];
    end
  endgenerate

  function automatic logic [CRC_W-1:0] crcStep(input logic [CRC_W-1:0] c, input logic b);
    logic fb;
    fb = c[CRC_W-1] ^ b;
    return {c[CRC_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
  endfunction

  logic [CRC_W-1:0]     crcReg, crcIn, crcNext;
  logic                 groupFlag, matchReg;
  logic                 isGroup, bitOk, matchNext, acceptNext;
  logic [HASH_BITS-1:0] hashIdx;

  always_comb begin
    crcIn      = strobes.start ? '1 : crcReg;
    crcNext    = crcStep(crcIn, bitIn);
    bitOk      = (bitIn == physVec[strobes.bitIdx]);
    matchNext  = (strobes.start | matchReg) & bitOk;
    isGroup    = strobes.start ? bitIn : groupFlag;
    hashIdx    = crcNext[CRC_W-1 -: HASH_BITS];
    acceptNext = isGroup ? filtVec[hashIdx] : matchNext;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      crcReg    <= '0;
      matchReg  <= 1'b0;
      groupFlag <= 1'b0;
      decValid  <= 1'b0;
      decAccept <= 1'b0;
    end else begin
      if (strobes.start | strobes.shift) begin
        crcReg   <= crcNext;
        matchReg <= matchNext;
      end
      if (strobes.start) begin
        groupFlag <= bitIn;
        decValid  <= 1'b0;
        decAccept <= 1'b0;
      end
      if (strobes.last) begin
        decValid  <= 1'b1;
        decAccept <= acceptNext;
      end
    end
  end
endmodule

// File: rtl/dafilt_top.sv
module dafilt_top
  import dafilt_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               bitIn,
  input  logic               bitValid,
  input  logic               sof,
  input  logic               regWrEn,
  input  logic [RADDR_W-1:0] regAddr,
  input  logic [BYTE_W-1:0]  regWrData,
  output logic               decisionValid,
  output logic               frameAccept,
  output logic               frameReject
);
  ctrlStrobes_t strobes;
  logic         decValid, decAccept;

  dafilt_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .bitValid(bitValid), .sof(sof), .strobes(strobes)
  );

  dafilt_dpath u_dpath (
    .clk(clk), .rstN(rstN), .bitIn(bitIn), .strobes(strobes),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .decValid(decValid), .decAccept(decAccept)
  );

  assign decisionValid = decValid;
  assign frameAccept   = decValid & decAccept;
  assign frameReject   = decValid & ~decAccept;
endmodule

// File: rtl/dafilt_checker.sv
module dafilt_checker (
  input logic clk,
  input logic rstN,
  input logic bitValid,
  input logic sof,
  input logic decisionValid,
  input logic frameAccept,
  input logic frameReject
);
  p_excl_r6: assert property (@(posedge clk) disable iff (!rstN)
    !(frameAccept && frameReject));

  p_accept_valid_r6: assert property (@(posedge clk) disable iff (!rstN)
    (frameAccept || frameReject) |-> decisionValid);

  p_decided_r6: assert property (@(posedge clk) disable iff (!rstN)
    decisionValid |-> (frameAccept || frameReject));

  p_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    (decisionValid && !(bitValid && sof)) |=> (decisionValid && $stable(frameAccept)));

  p_restart_clear_r7: assert property (@(posedge clk) disable iff (!rstN)
    (bitValid && sof) |=> !decisionValid);
endmodule

bind dafilt_top dafilt_checker u_chk (.*);

// File: tb/dafilt_top_bench.sv
`timescale 1ns/1ps
module dafilt_top_bench;
  localparam real CLK_HALF = 2.5;

  logic clk = 0, rstN = 0;
  logic bitIn = 0, bitValid = 0, sof = 0;
  logic regWrEn = 0;
  logic [3:0] regAddr = 0;
  logic [7:0] regWrData = 0;
  logic decisionValid, frameAccept, frameReject;

  int nChecks = 0, nFails = 0;
  bit finished = 0;
  logic [47:0] physModel = '0;
  logic [63:0] filtModel = '0;

  always #(CLK_HALF) clk = ~clk;

  dafilt_top u_dafilt_top (.*);

  function automatic logic [5:0] hashOf(input logic [47:0] da);
    logic [31:0] c;
    logic fb;
    c = '1;
    for (int i = 0; i < 48; i++) begin
      fb = c[31] ^ da[i];
      c = {c[30:0], 1'b0} ^ (fb ? 32'h04C11DB7 : 32'h0);
    end
    return c[31:26];
  endfunction

  function automatic logic expAccept(input logic [47:0] da);
    if (da[0]) return filtModel[hashOf(da)];
    return da == physModel;
  endfunction

  task automatic check(input logic expValid, input logic expAcc, input string req);
    logic [2:0] act, exp;
    act = {decisionValid, frameAccept, frameReject};
    exp = {expValid, expValid & expAcc, expValid & ~expAcc};
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: {valid,accept,reject} actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic writeReg(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    regWrEn = 1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 0;
  endtask

  task automatic writePhys(input logic [47:0] v);
    for (int k = 0; k < 6; k++) writeReg(4'(k), v[8*k +: 8]);
    physModel = v;
  endtask

  task automatic writeFilt(input logic [63:0] f);
    for (int k = 0; k < 8; k++) writeReg(4'(8 + k), f[8*k +: 8]);
    filtModel = f;
  endtask

  // Drive one bit at a negedge; idle gaps with stray sof/bit (R8) may precede it.
  task automatic driveBit(input logic b, input logic s, input bit gaps);
    if (gaps && ($urandom % 4 == 0)) begin
      @(negedge clk);
      bitValid = 0; sof = 1'($urandom); bitIn = 1'($urandom);
    end
    @(negedge clk);
    bitValid = 1; sof = s; bitIn = b;
  endtask

  task automatic sendFrame(input logic [47:0] da, input bit gaps, input string req);
    for (int i = 0; i < 48; i++) begin
      driveBit(da[i], i == 0, gaps);
      if (i == 47) check(1'b0, 1'b0, "R6 no decision before bit 47");
    end
    @(negedge clk);
    bitValid = 0; sof = 0;
    check(1'b1, expAccept(da), req);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check(1'b0, 1'b0, "R1 reset outputs");
    rstN = 1;
    @(negedge clk);
    check(1'b0, 1'b0, "R1 outputs after reset release");

    // R1: registers zero -> all-zero unicast address matches
    sendFrame(48'h0, 0, "R1 zero registers match zero address");

    // R8: valid bits without sof are not assembled
    begin
      logic [47:0] g;
      g = {$urandom, $urandom};
      sendFrame(48'h0, 0, "R8 setup");
      for (int i = 0; i < 48; i++) driveBit(g[i], 1'b0, 0);
      @(negedge clk); bitValid = 0;
      check(1'b1, 1'b1, "R8 bits after bit 47 ignored");
    end

    begin
      logic [47:0] st;
      st = 48'h1A2B3C4D5E60;
      writePhys(st);
      sendFrame(st, 1, "R3 exact station match");
      for (int k = 0; k < 6; k++) begin
        logic [47:0] bad;
        bad = st ^ (48'h1 << (8*k + 1 + (k % 7)));
        sendFrame(bad, 0, $sformatf("R3 mismatch in byte %0d", k));
      end
      // R2: group bit set, address equals station, filter zero -> reject
      writePhys(st | 48'h1);
      writeFilt(64'h0);
      sendFrame(st | 48'h1, 0, "R2 group bit forces hash path");
      // R2: unicast mismatch with full filter -> reject
      writeFilt('1);
      sendFrame(st ^ 48'h100, 0, "R2 unicast ignores filter");
      writePhys(st);
    end

    // R5/R4: single filter bit hit vs neighbour
    for (int t = 0; t < 8; t++) begin
      logic [47:0] da;
      logic [5:0] h;
      da = {$urandom, $urandom} | 48'h1;
      h = hashOf(da);
      writeFilt(64'h1 << h);
      sendFrame(da, 0, "R5 only indexed filter bit set");
      writeFilt(64'h1 << (h ^ 6'h1));
      sendFrame(da, 0, "R4 neighbour filter bit only");
    end

    // R7: restart mid-address
    begin
      logic [47:0] junk;
      junk = {$urandom, $urandom};
      sendFrame(physModel, 0, "R7 setup");
      driveBit(junk[0], 1'b1, 0);
      @(negedge clk); bitValid = 0;
      check(1'b0, 1'b0, "R7 sof clears decision");
      for (int i = 1; i < 20; i++) driveBit(junk[i], 1'b0, 0);
      sendFrame(physModel, 0, "R7 restart mid-address");
    end

    // R6: decision holds through idle and extra bits
    sendFrame(physModel ^ 48'h10000, 0, "R6 setup");
    for (int i = 0; i < 30; i++) driveBit(1'($urandom), 1'b0, 1);
    @(negedge clk); bitValid = 0;
    check(1'b1, 1'b0, "R6 decision held until sof");

    // Random mix (R2 R3 R4 R5)
    for (int t = 0; t < 150; t++) begin
      logic [47:0] da;
      int kind;
      if (t % 10 == 0) writeFilt({$urandom, $urandom});
      kind = $urandom % 3;
      if (kind == 0) da = physModel;
      else if (kind == 1) da = {$urandom, $urandom} & ~48'h1;
      else da = {$urandom, $urandom} | 48'h1;
      sendFrame(da, 1, da[0] ? "R4 random multicast" : "R3 random unicast");
    end

    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    #(CLK_HALF * 2 * 150000);
    if (!finished) begin
      finished = 1;
      nChecks++; nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end
endmodule